// File: doc/BRIEF.md
# Gyro Loop Health Monitor

This block watches the running subsystems of a closed-loop vibratory gyro readout and keeps one health flag for each: the sense loop, the drive oscillation and the clock synthesizer lock. A combined fail-safe flag is high only while all three are good. Each flag comes out of reset in the not-good state. It becomes good only after a programmable run of good evidence, and it drops as soon as bad evidence is seen.

Sense-loop stability is judged from the single-bit modulator stream. A loop that has lost control sits at one output value for a long time, so an over-long run of identical bits marks the loop unstable. Drive amplitude words are compared against a two-sided window whose limits are inputs. The raw lock indication comes from another clock domain. It is synchronized, and it must stay high for a programmable number of cycles before it is reported.

The limits and streak lengths are plain inputs, held steady by the surrounding logic. The three flags share one qualifier structure that counts consecutive good events.

Top module: `gyro_health_mon`

## Requirements
- R1: While rst_ni is low, and right after it rises, sense_ok_o, drive_ok_o, lock_ok_o and all_ok_o are all 0.
- R2: The run length counts the valid sense samples (sense_vld_i=1) in the current run of equal bits. A run starts at 1 on the first valid sample after reset or on a bit change. A valid sample that makes the run length greater than run_max_i clears sense_ok_o on the clock edge that takes it. A run exactly equal to run_max_i does not clear the flag.
- R3: A run is complete when a valid sample of the other bit value arrives. It is good if it never went past run_max_i. sense_ok_o is set at the edge that completes a good run, once the count of consecutive good completed runs reaches sense_need_i (0 behaves as 1). A violation, or completing a run that went past the limit, resets that count to 0.
- R4: Cycles with sense_vld_i=0 are ignored. They neither end a run nor lengthen it, whatever sense_bit_i is.
- R5: A valid amplitude sample (amp_vld_i=1) is in the window when amp_lo_i <= amp_i <= amp_hi_i (unsigned, both limits included). A valid sample outside the window clears drive_ok_o at the edge that takes it.
- R6: drive_ok_o is set at the edge that takes the drive_need_i-th consecutive valid in-window sample (0 behaves as 1). Cycles with amp_vld_i=0 neither break nor extend the streak.
- R7: lock_raw_i passes through two synchronizing flops. If it rises before edge 1 and stays high, lock_ok_o goes to 1 after edge 2+lock_need_i (lock_need_i=0 behaves as 1).
- R8: If lock_raw_i falls before edge 1, lock_ok_o is 0 after edge 2, and the hold count starts again from zero.
- R9: all_ok_o is 1 exactly when sense_ok_o, drive_ok_o and lock_ok_o are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sense_bit_i | input | 1 | Sense modulator output bit |
| sense_vld_i | input | 1 | Sense bit valid strobe |
| run_max_i | input | RUN_W | Longest allowed run of equal sense bits |
| sense_need_i | input | CNT_W | Good runs needed to set the sense flag |
| amp_i | input | AMP_W | Drive amplitude word |
| amp_vld_i | input | 1 | Amplitude word valid strobe |
| amp_lo_i | input | AMP_W | Lower amplitude limit (inclusive) |
| amp_hi_i | input | AMP_W | Upper amplitude limit (inclusive) |
| drive_need_i | input | CNT_W | In-window samples needed to set the drive flag |
| lock_raw_i | input | 1 | Asynchronous lock indication |
| lock_need_i | input | CNT_W | Synchronized high cycles needed to set the lock flag |
| sense_ok_o | output | 1 | Sense loop healthy |
| drive_ok_o | output | 1 | Drive amplitude healthy |
| lock_ok_o | output | 1 | Clock lock healthy |
| all_ok_o | output | 1 | Combined fail-safe flag |

## Verification
The assertions check every cycle that a violating sense run or an out-of-window amplitude sample leaves its flag low on the next cycle. They also check that each flag rises only right after a qualifying event, and that the lock flag is low two edges after the raw input was low. The exact streak lengths need the bench's scenarios: the run length at which the sense flag drops, the number of good runs or samples before a flag returns, and the edge at which lock is first reported. So do the limit-equal cases, the invisibility of non-valid cycles, and the combined flag.

// File: rtl/gyro_health_pkg.sv
package gyro_health_pkg;
  localparam int N_MON = 3;

  typedef enum logic [1:0] {
    MON_SENSE = 2'd0,
    MON_DRIVE = 2'd1,
    MON_LOCK  = 2'd2
  } mon_idx_e;

  typedef struct packed {
    logic lock;
    logic drive;
    logic sense;
  } health_t;
endpackage

// File: rtl/streak_qual.sv
// Sets ok after target consecutive hits; any miss clears it at once.
module streak_qual #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic             miss_i,
  input  logic [CNT_W-1:0] target_i,
  output logic             ok_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             ok_q;

  assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ok_q  <= 1'b0;
    end else if (miss_i) begin
      cnt_q <= '0;
      ok_q  <= 1'b0;
    end else if (hit_i) begin
      cnt_q <= cnt_inc;
      if (cnt_inc >= target_i) ok_q <= 1'b1;
    end
  end

  assign ok_o = ok_q;
endmodule

// File: rtl/sense_run_mon.sv
// Tracks runs of equal sense bits; flags good run ends and over-long runs.
module sense_run_mon #(
  parameter int RUN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_i,
  input  logic             vld_i,
  input  logic [RUN_W-1:0] run_max_i,
  output logic             good_end_o,
  output logic             over_o
);
  localparam logic [RUN_W-1:0] RUN_SAT = {RUN_W{1'b1}};

  logic             started_q;
  logic             prev_q;
  logic [RUN_W-1:0] run_q;
  logic             run_bad_q;
  logic             same;
  logic [RUN_W-1:0] run_nx;
  logic             too_long;

  assign same     = started_q && (bit_i == prev_q);
  assign run_nx   = same ? ((run_q == RUN_SAT) ? run_q : run_q + 1'b1)
                         : {{(RUN_W-1){1'b0}}, 1'b1};
  assign too_long = run_nx > run_max_i;

  assign over_o     = vld_i && too_long;
  assign good_end_o = vld_i && started_q && !same && !run_bad_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      prev_q    <= 1'b0;
      run_q     <= '0;
      run_bad_q <= 1'b0;
    end else if (vld_i) begin
      started_q <= 1'b1;
      prev_q    <= bit_i;
      run_q     <= run_nx;
      run_bad_q <= (same && run_bad_q) || too_long;
    end
  end
endmodule

// File: rtl/amp_window.sv
// Two-sided inclusive window test on valid amplitude words.
module amp_window #(
  parameter int AMP_W = 16
) (
  input  logic [AMP_W-1:0] amp_i,
  input  logic             vld_i,
  input  logic [AMP_W-1:0] lo_i,
  input  logic [AMP_W-1:0] hi_i,
  output logic             in_o,
  output logic             out_o
);
  logic in_win;

  assign in_win = (amp_i >= lo_i) && (amp_i <= hi_i);
  assign in_o   = vld_i && in_win;
  assign out_o  = vld_i && !in_win;
endmodule

// File: rtl/lock_sync.sv
// Two-flop synchronizer for the asynchronous lock indication.
module lock_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic sync_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
    end
  end

  assign sync_o = s2_q;
endmodule

// File: rtl/gyro_health_mon.sv
module gyro_health_mon
  import gyro_health_pkg::*;
#(
  parameter int RUN_W = 8,
  parameter int CNT_W = 8,
  parameter int AMP_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sense_bit_i,
  input  logic             sense_vld_i,
  input  logic [RUN_W-1:0] run_max_i,
  input  logic [CNT_W-1:0] sense_need_i,
  input  logic [AMP_W-1:0] amp_i,
  input  logic             amp_vld_i,
  input  logic [AMP_W-1:0] amp_lo_i,
  input  logic [AMP_W-1:0] amp_hi_i,
  input  logic [CNT_W-1:0] drive_need_i,
  input  logic             lock_raw_i,
  input  logic [CNT_W-1:0] lock_need_i,
  output logic             sense_ok_o,
  output logic             drive_ok_o,
  output logic             lock_ok_o,
  output logic             all_ok_o
);
  logic             sense_hit, sense_miss;
  logic             amp_in, amp_out;
  logic             lock_s;
  logic [N_MON-1:0] hit, miss, qual;
  logic [CNT_W-1:0] target [N_MON];
  health_t          health;

  sense_run_mon #(.RUN_W(RUN_W)) u_sense (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_i      (sense_bit_i),
    .vld_i      (sense_vld_i),
    .run_max_i  (run_max_i),
    .good_end_o (sense_hit),
    .over_o     (sense_miss)
  );

  amp_window #(.AMP_W(AMP_W)) u_amp (
    .amp_i (amp_i),
    .vld_i (amp_vld_i),
    .lo_i  (amp_lo_i),
    .hi_i  (amp_hi_i),
    .in_o  (amp_in),
    .out_o (amp_out)
  );

  lock_sync u_lock (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (lock_raw_i),
    .sync_o (lock_s)
  );

  always_comb begin
    hit[MON_SENSE]     = sense_hit;
    miss[MON_SENSE]    = sense_miss;
    target[MON_SENSE]  = sense_need_i;
    hit[MON_DRIVE]     = amp_in;
    miss[MON_DRIVE]    = amp_out;
    target[MON_DRIVE]  = drive_need_i;
    hit[MON_LOCK]      = lock_s;
    miss[MON_LOCK]     = !lock_s;
    target[MON_LOCK]   = lock_need_i;
  end

  for (genvar g = 0; g < N_MON; g++) begin : g_qual
    streak_qual #(.CNT_W(CNT_W)) u_q (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .hit_i    (hit[g]),
      .miss_i   (miss[g]),
      .target_i (target[g]),
      .ok_o     (qual[g])
    );
  end

  // lock flag drops with the synchronized input, not one cycle later
  assign health.sense = qual[MON_SENSE];
  assign health.drive = qual[MON_DRIVE];
  assign health.lock  = qual[MON_LOCK] && lock_s;

  assign sense_ok_o = health.sense;
  assign drive_ok_o = health.drive;
  assign lock_ok_o  = health.lock;
  assign all_ok_o   = &health;
endmodule

// File: rtl/gyro_health_mon_chk.sv
module gyro_health_mon_chk #(
  parameter int AMP_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [AMP_W-1:0] amp_i,
  input logic             amp_vld_i,
  input logic [AMP_W-1:0] amp_lo_i,
  input logic [AMP_W-1:0] amp_hi_i,
  input logic             lock_raw_i,
  input logic             sense_hit_i,
  input logic             sense_miss_i,
  input logic             sense_ok_o,
  input logic             drive_ok_o,
  input logic             lock_ok_o
);
  a_r2_miss_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sense_miss_i |=> !sense_ok_o);

  a_r3_rise_on_good_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sense_ok_o) |-> $past(sense_hit_i));

  a_r5_out_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (amp_vld_i && (amp_i > amp_hi_i || amp_i < amp_lo_i)) |=> !drive_ok_o);

  a_r6_rise_on_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drive_ok_o) |-> $past(amp_vld_i && amp_i >= amp_lo_i && amp_i <= amp_hi_i));

  a_r7_rise_needs_raw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_ok_o) |-> $past(lock_raw_i, 2));

  a_r8_low_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(lock_raw_i, 2) |-> !lock_ok_o);
endmodule

bind gyro_health_mon gyro_health_mon_chk #(.AMP_W(AMP_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .amp_i        (amp_i),
  .amp_vld_i    (amp_vld_i),
  .amp_lo_i     (amp_lo_i),
  .amp_hi_i     (amp_hi_i),
  .lock_raw_i   (lock_raw_i),
  .sense_hit_i  (sense_hit),
  .sense_miss_i (sense_miss),
  .sense_ok_o   (sense_ok_o),
  .drive_ok_o   (drive_ok_o),
  .lock_ok_o    (lock_ok_o)
);

// File: tb/gyro_health_mon_test.sv
module gyro_health_mon_test;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_W = 8;
  localparam int CNT_W = 8;
  localparam int AMP_W = 16;
  localparam int N_VEC = 10;

  // drive table: valid, amplitude, expected drive_ok after the edge (lo=100 hi=200 need=2)
  localparam int VEC_VLD [N_VEC] = '{1, 1, 0, 1, 1, 0, 1, 1, 1, 1};
  localparam int VEC_AMP [N_VEC] = '{150, 100, 50, 201, 200, 0, 120, 99, 150, 150};
  localparam int VEC_EXP [N_VEC] = '{0, 1, 1, 0, 0, 0, 1, 0, 0, 1};

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             sense_bit_i = 1'b0;
  logic             sense_vld_i = 1'b0;
  logic [RUN_W-1:0] run_max_i = 8'd3;
  logic [CNT_W-1:0] sense_need_i = 8'd2;
  logic [AMP_W-1:0] amp_i = '0;
  logic             amp_vld_i = 1'b0;
  logic [AMP_W-1:0] amp_lo_i = 16'd100;
  logic [AMP_W-1:0] amp_hi_i = 16'd200;
  logic [CNT_W-1:0] drive_need_i = 8'd2;
  logic             lock_raw_i = 1'b0;
  logic [CNT_W-1:0] lock_need_i = 8'd3;
  logic             sense_ok_o, drive_ok_o, lock_ok_o, all_ok_o;

  int n_chk = 0;
  int n_fail = 0;

  gyro_health_mon #(.RUN_W(RUN_W), .CNT_W(CNT_W), .AMP_W(AMP_W)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .sense_bit_i(sense_bit_i), .sense_vld_i(sense_vld_i),
    .run_max_i(run_max_i), .sense_need_i(sense_need_i),
    .amp_i(amp_i), .amp_vld_i(amp_vld_i), .amp_lo_i(amp_lo_i), .amp_hi_i(amp_hi_i),
    .drive_need_i(drive_need_i), .lock_raw_i(lock_raw_i), .lock_need_i(lock_need_i),
    .sense_ok_o(sense_ok_o), .drive_ok_o(drive_ok_o),
    .lock_ok_o(lock_ok_o), .all_ok_o(all_ok_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic sense_send(input logic b);
    sense_bit_i = b;
    sense_vld_i = 1'b1;
    tick();
    sense_vld_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk_i);
    check("R1 sense", sense_ok_o, 1'b0);
    check("R1 drive", drive_ok_o, 1'b0);
    check("R1 lock", lock_ok_o, 1'b0);
    check("R1 all", all_ok_o, 1'b0);
    rst_ni = 1'b1;
    tick();
    check("R1 after release", all_ok_o, 1'b0);

    // R5/R6 drive window table
    for (int i = 0; i < N_VEC; i++) begin
      amp_i = AMP_W'(VEC_AMP[i]);
      amp_vld_i = (VEC_VLD[i] != 0);
      tick();
      check($sformatf("R5/R6 vec %0d", i), drive_ok_o, VEC_EXP[i] != 0);
    end
    amp_vld_i = 1'b0;

    // R3 recovery after two good runs (run_max=3, need=2)
    sense_send(0); sense_send(0);
    sense_send(1); check("R3 one good run", sense_ok_o, 1'b0);
    sense_send(1); sense_send(1);
    sense_send(0); check("R3 two good runs", sense_ok_o, 1'b1);
    // R2 run equal to limit keeps flag, one more clears
    sense_send(0); sense_send(0);
    check("R2 run at limit", sense_ok_o, 1'b1);
    sense_send(0); check("R2 run over limit", sense_ok_o, 1'b0);
    sense_send(1); check("R3 bad run not counted", sense_ok_o, 1'b0);
    sense_send(0); check("R3 one good after bad", sense_ok_o, 1'b0);
    sense_send(1); check("R3 recovered", sense_ok_o, 1'b1);
    // R4 non-valid cycles neither end nor extend the run of ones
    sense_bit_i = 1'b0;
    repeat (3) tick();
    check("R4 idle keeps flag", sense_ok_o, 1'b1);
    sense_send(1); sense_send(1);
    check("R4 run at limit", sense_ok_o, 1'b1);
    sense_send(1); check("R4 gap did not split run", sense_ok_o, 1'b0);
    sense_send(0); sense_send(1); sense_send(0);
    check("R3 restored", sense_ok_o, 1'b1);

    // R7 lock qualification, need=3: rises after edge 5
    lock_raw_i = 1'b1;
    repeat (4) tick();
    check("R7 before hold", lock_ok_o, 1'b0);
    tick();
    check("R7 after hold", lock_ok_o, 1'b1);
    check("R9 all good", all_ok_o, 1'b1);
    // R8 fall: low after edge 2
    lock_raw_i = 1'b0;
    tick();
    check("R8 sync delay", lock_ok_o, 1'b1);
    tick();
    check("R8 fell", lock_ok_o, 1'b0);
    check("R9 lock drop", all_ok_o, 1'b0);
    // R8 short pulse then restart of the hold count
    lock_raw_i = 1'b1;
    repeat (4) tick();
    lock_raw_i = 1'b0;
    repeat (2) tick();
    check("R8 short pulse", lock_ok_o, 1'b0);
    lock_raw_i = 1'b1;
    repeat (4) tick();
    check("R8 count restarted", lock_ok_o, 1'b0);
    tick();
    check("R7 relocked", lock_ok_o, 1'b1);
    check("R9 all good again", all_ok_o, 1'b1);

    // R5 above upper limit drops drive and the combined flag
    amp_i = 16'd300;
    amp_vld_i = 1'b1;
    tick();
    amp_vld_i = 1'b0;
    check("R5 above window", drive_ok_o, 1'b0);
    check("R9 drive drop", all_ok_o, 1'b0);

    // R1 asynchronous reset clears flags
    rst_ni = 1'b0;
    #1;
    check("R1 async sense", sense_ok_o, 1'b0);
    check("R1 async lock", lock_ok_o, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule